// File: doc/BRIEF.md
# Binary Tree Up-Down Route Unit

This unit works out the path a packet takes through a binary tree network whose leaves are the processing nodes. A leaf address is an n-bit word read from the root downward, one bit per level, where 0 selects the left child and 1 the right child. The tree has log2 of the leaf count levels, so any route is logarithmic in the number of leaves.

A request carries a source leaf and a destination leaf on a valid/ready handshake. The unit XORs the two addresses to get a relative address. The most significant set bit of that value, at position p, means the packet must climb p+1 levels to reach the nearest common ancestor. The unit reports that climb height. It then issues a stream of hop commands, one per accepted cycle: first the UP hops, then DOWN hops whose left/right choice is taken from destination bits p down to 0. When source and destination are the same leaf, it issues a single LOCAL command instead. The unit takes a new request only after the consumer has taken the last hop command of the current route.

Top module: `tree_updown_router`

## Requirements
- R1: After reset, req_ready is 1 and hop_valid is 0.
- R2: While a route is being issued, route_climb equals p+1, where p is the position of the highest set bit of req_src XOR req_dst. It equals 0 when the two addresses are equal.
- R3: For a route with climb c > 0, the first c hop commands are UP (hop_kind 2'b00, hop_dir 0).
- R4: After the UP hops, exactly c DOWN hops (hop_kind 2'b01) follow. The k-th of them (k = 0..c-1) carries hop_dir equal to destination bit c-1-k, where 1 means the right child.
- R5: When req_src equals req_dst, exactly one command is issued: LOCAL (hop_kind 2'b10, hop_dir 0, hop_last 1).
- R6: hop_last is 1 only on the final command of a route. In the cycle after that command is taken, req_ready is 1 and hop_valid is 0.
- R7: req_ready is 0 while a route is being issued. req_valid asserted during that time has no effect on the hop stream.
- R8: While hop_valid is 1 and hop_ready is 0, hop_kind, hop_dir and hop_last hold their values, and hop_valid stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Route request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_src | input | AW | Source leaf address |
| req_dst | input | AW | Destination leaf address |
| hop_valid | output | 1 | Hop command present |
| hop_ready | input | 1 | Consumer takes the hop command |
| hop_kind | output | 2 | 00 UP, 01 DOWN, 10 LOCAL |
| hop_dir | output | 1 | Child for a DOWN hop: 0 left, 1 right |
| hop_last | output | 1 | Final command of the route |
| route_climb | output | CW | Levels to climb for the current route |

## Verification
Every source and destination pair of the default 16-leaf tree is routed. This covers equal addresses (the LOCAL case), pairs that differ only in bit 0 (one level up and one down), pairs that differ in the top bit (a full climb to the root), and pairs whose lower bits differ in mixed ways. The mixed cases show whether the descent follows the destination bits rather than the source bits or the XOR. The consumer's ready signal is random, so back-to-back hops and stalls both occur. In a dedicated phase, the consumer is held stalled for several cycles on a full-height route while a stray request is driven. This shows whether the stall holds the command steady and whether the stray request is ignored.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;

  typedef enum logic [1:0] {
    HOP_UP    = 2'b00,
    HOP_DOWN  = 2'b01,
    HOP_LOCAL = 2'b10
  } hop_kind_e;

  // Position of the highest set bit; returns 0 for a zero word.
  function automatic int unsigned top_one(input logic [31:0] v);
    int unsigned p;
    p = 0;
    for (int b = 0; b < 32; b++) begin
      if (v[b]) p = b;
    end
    return p;
  endfunction

  // Levels to climb for a relative address: 0 when equal, else top_one+1.
  function automatic int unsigned climb_of(input logic [31:0] rel);
    return (rel == 32'd0) ? 0 : top_one(rel) + 1;
  endfunction

endpackage

// File: rtl/tree_route_calc.sv
module tree_route_calc
  import tree_route_pkg::*;
#(
  parameter int AW = 4,
  parameter int CW = 3
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  output logic [AW-1:0] rel,
  output logic [CW-1:0] climb,
  output logic          same_leaf
);

  always_comb begin
    rel       = src ^ dst;
    same_leaf = (rel == '0);
    climb     = CW'(climb_of(32'(rel)));
  end

endmodule

// File: rtl/tree_hop_seq.sv
module tree_hop_seq
  import tree_route_pkg::*;
#(
  parameter int AW = 4,
  parameter int CW = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_dst,
  input  logic [CW-1:0] start_climb,
  input  logic          start_local,
  input  logic          take,
  output logic          busy,
  output hop_kind_e     kind,
  output logic          dir,
  output logic          last,
  output logic [CW-1:0] climb_out
);

  logic          busy_q;
  hop_kind_e     kind_q;
  logic [CW-1:0] ups_left_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] dst_q;
  logic [CW-1:0] climb_q;

  // Named internal events
  logic hop_fire;
  logic up_done;
  logic down_done;

  assign hop_fire  = busy_q && take;
  assign up_done   = hop_fire && (kind_q == HOP_UP) && (ups_left_q == CW'(1));
  assign down_done = hop_fire && (kind_q == HOP_DOWN) && (idx_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      kind_q     <= HOP_LOCAL;
      ups_left_q <= '0;
      idx_q      <= '0;
      dst_q      <= '0;
      climb_q    <= '0;
    end else if (start) begin
      busy_q     <= 1'b1;
      dst_q      <= start_dst;
      climb_q    <= start_climb;
      ups_left_q <= start_climb;
      idx_q      <= start_local ? '0 : IW'(start_climb - CW'(1));
      kind_q     <= start_local ? HOP_LOCAL : HOP_UP;
    end else if (hop_fire) begin
      unique case (kind_q)
        HOP_LOCAL: busy_q <= 1'b0;
        HOP_UP: begin
          ups_left_q <= ups_left_q - CW'(1);
          if (up_done) kind_q <= HOP_DOWN;
        end
        HOP_DOWN: begin
          if (down_done) busy_q <= 1'b0;
          else           idx_q  <= idx_q - IW'(1);
        end
        default: busy_q <= 1'b0;
      endcase
    end
  end

  always_comb begin
    busy      = busy_q;
    kind      = kind_q;
    dir       = (kind_q == HOP_DOWN) ? dst_q[idx_q] : 1'b0;
    last      = (kind_q == HOP_LOCAL) || ((kind_q == HOP_DOWN) && (idx_q == '0));
    climb_out = climb_q;
  end

  // R3: an UP phase always has hops left to issue
  a_r3_up_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && kind_q == HOP_UP) |-> (ups_left_q != '0));

  // R4: the descent index never points past the climbed height
  a_r4_idx_in_climb: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && kind_q == HOP_DOWN) |-> (CW'(idx_q) < climb_q));

  // R3: the last UP hop hands over to DOWN with the full index
  a_r3_handover: assert property (@(posedge clk) disable iff (!rst_n)
    up_done |=> (kind_q == HOP_DOWN && CW'(idx_q) == climb_q - CW'(1)));

endmodule

// File: rtl/tree_updown_router.sv
module tree_updown_router
  import tree_route_pkg::*;
#(
  parameter int LEAVES = 16,
  localparam int AW = (LEAVES > 2) ? $clog2(LEAVES) : 2,
  localparam int CW = $clog2(AW + 1),
  localparam int IW = (AW > 2) ? $clog2(AW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_src,
  input  logic [AW-1:0] req_dst,
  output logic          hop_valid,
  input  logic          hop_ready,
  output logic [1:0]    hop_kind,
  output logic          hop_dir,
  output logic          hop_last,
  output logic [CW-1:0] route_climb
);

  logic [AW-1:0] rel;
  logic [CW-1:0] climb;
  logic          same_leaf;
  logic          busy;
  hop_kind_e     kind;
  logic          accept;
  logic          hop_take;

  tree_route_calc #(.AW(AW), .CW(CW)) u_calc (
    .src       (req_src),
    .dst       (req_dst),
    .rel       (rel),
    .climb     (climb),
    .same_leaf (same_leaf)
  );

  assign accept = req_valid && !busy;

  tree_hop_seq #(.AW(AW), .CW(CW), .IW(IW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_dst   (req_dst),
    .start_climb (climb),
    .start_local (same_leaf),
    .take        (hop_ready),
    .busy        (busy),
    .kind        (kind),
    .dir         (hop_dir),
    .last        (hop_last),
    .climb_out   (route_climb)
  );

  assign req_ready = !busy;
  assign hop_valid = busy;
  assign hop_kind  = kind;
  assign hop_take  = hop_valid && hop_ready;

  // R8: a stalled command holds still
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_valid && !hop_ready) |=> (hop_valid && $stable(hop_kind) &&
                                   $stable(hop_dir) && $stable(hop_last)));

  // R7: no request taken while hops are pending
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    hop_valid |-> !req_ready);

  // R5: LOCAL is a lone final command with zero climb
  a_r5_local_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_valid && hop_kind == HOP_LOCAL) |-> (hop_last && route_climb == '0));

  // R6: after the final command the unit is idle
  a_r6_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_take && hop_last) |=> (req_ready && !hop_valid));

  // R3: no UP once the descent has begun
  a_r3_no_up_after_down: assert property (@(posedge clk) disable iff (!rst_n)
    (hop_take && hop_kind == HOP_DOWN && !hop_last) |=> (hop_kind == HOP_DOWN));

  // R2: climb stays within the tree height and is nonzero except for LOCAL
  a_r2_climb_range: assert property (@(posedge clk) disable iff (!rst_n)
    hop_valid |-> (route_climb <= CW'(AW) &&
                   ((route_climb == '0) == (hop_kind == HOP_LOCAL))));

endmodule

// File: tb/tree_updown_router_tb.sv
module tree_updown_router_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LEAVES = 16;
  localparam int AW = $clog2(LEAVES);
  localparam int CW = $clog2(AW + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_src = '0;
  logic [AW-1:0] req_dst = '0;
  logic          hop_valid;
  logic          hop_ready = 1'b0;
  logic [1:0]    hop_kind;
  logic          hop_dir;
  logic          hop_last;
  logic [CW-1:0] route_climb;

  int checks = 0;
  int errors = 0;
  bit stall = 1'b1;

  typedef struct packed {
    logic [1:0]    kind;
    logic          dir;
    logic          last;
    logic [CW-1:0] climb;
  } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tree_updown_router #(.LEAVES(LEAVES)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst),
    .hop_valid(hop_valid), .hop_ready(hop_ready),
    .hop_kind(hop_kind), .hop_dir(hop_dir), .hop_last(hop_last),
    .route_climb(route_climb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: scan from the top bit for the first mismatch
  task automatic push_route(input logic [AW-1:0] s, input logic [AW-1:0] d);
    int h;
    exp_t e;
    h = -1;
    for (int b = AW - 1; b >= 0; b--) begin
      if (h < 0 && s[b] != d[b]) h = b;
    end
    if (h < 0) begin
      e = '{kind: 2'b10, dir: 1'b0, last: 1'b1, climb: '0};
      expq.push_back(e);
    end else begin
      for (int u = 0; u <= h; u++) begin
        e = '{kind: 2'b00, dir: 1'b0, last: 1'b0, climb: CW'(h + 1)};
        expq.push_back(e);
      end
      for (int b = h; b >= 0; b--) begin
        e = '{kind: 2'b01, dir: d[b], last: (b == 0), climb: CW'(h + 1)};
        expq.push_back(e);
      end
    end
  endtask

  task automatic send(input logic [AW-1:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_src = s;
    req_dst = d;
    push_route(s, d);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: sets ready, then compares whatever will be taken at the next edge
  initial begin
    bit   held;
    bit   after_last;
    exp_t prev;
    exp_t e;
    held = 1'b0;
    after_last = 1'b0;
    forever begin
      @(negedge clk);
      hop_ready = stall ? 1'b0 : ($urandom_range(3) != 0);
      #1;
      if (after_last) begin
        check(req_ready && !hop_valid, "R6 idle after last", int'(req_ready), 1);
        after_last = 1'b0;
      end
      if (held) begin
        check(hop_valid && hop_kind == prev.kind && hop_dir == prev.dir &&
              hop_last == prev.last, "R8 hold", int'(hop_kind), int'(prev.kind));
        held = 1'b0;
      end
      if (hop_valid && !hop_ready) begin
        held = 1'b1;
        prev = '{kind: hop_kind, dir: hop_dir, last: hop_last, climb: route_climb};
      end
      if (hop_valid && hop_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R6 unexpected hop", int'(hop_kind), -1);
        end else begin
          e = expq.pop_front();
          case (e.kind)
            2'b00: check(hop_kind == e.kind && hop_dir == e.dir, "R3 up hop",
                         int'({hop_kind, hop_dir}), int'({e.kind, e.dir}));
            2'b01: check(hop_kind == e.kind && hop_dir == e.dir, "R4 down hop",
                         int'({hop_kind, hop_dir}), int'({e.kind, e.dir}));
            default: check(hop_kind == e.kind && hop_dir == e.dir, "R5 local hop",
                         int'({hop_kind, hop_dir}), int'({e.kind, e.dir}));
          endcase
          check(hop_last == e.last, "R6 last flag", int'(hop_last), int'(e.last));
          check(route_climb == e.climb, "R2 climb", int'(route_climb), int'(e.climb));
          if (hop_last) after_last = 1'b1;
        end
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(hop_valid == 1'b0, "R1 no hop after reset", int'(hop_valid), 0);

    // R7: full-height route under a stall while a stray request is driven
    send(4'b0101, 4'b1010);
    for (int k = 0; k < 4; k++) begin
      check(req_ready == 1'b0, "R7 busy blocks", int'(req_ready), 0);
      req_valid = 1'b1;
      req_src = AW'(k);
      req_dst = ~AW'(k);
      @(negedge clk);
    end
    req_valid = 1'b0;
    stall = 1'b0;

    // Every pair of leaves
    for (int s = 0; s < LEAVES; s++) begin
      for (int d = 0; d < LEAVES; d++) begin
        send(AW'(s), AW'(d));
      end
    end

    while (expq.size() != 0 || hop_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    check(expq.size() == 0 && !hop_valid, "R7 no extra route", expq.size(), 0);
    summary();
  end

endmodule